// File: doc/BRIEF.md
# Serial Controller Register Block with Prioritised Interrupt

This block is the processor-facing register file of a 16450-class serial controller. A host reaches eight byte-wide registers through a 3-bit offset with separate read and write strobes. Read data is combinational and valid in the same cycle as the strobe. Any side effect of a read or write takes hold at the clock edge that ends the strobe cycle. The block holds the baud divisor, line control, interrupt enable, modem control, modem status and scratch registers. It forms a prioritised interrupt identification code and drives a single interrupt request.

On the line side there is a byte-level port instead of a serial shifter. Received bytes and break events come in on this port. A transmitted byte goes out with a one-cycle valid strobe, and the transmitter is treated as finished at once. Overrun, parity and framing flags always read as zero.

Register offsets are: 0 data (divisor low when divisor access is on), 1 interrupt enable (divisor high when divisor access is on), 2 interrupt identification, 3 line control, 4 modem control, 5 line status, 6 modem status, 7 scratch.

Top module: `uart_regfile`

## Requirements
- R1: While line control bit 7 is 1, offsets 0 and 1 read and write the low and high divisor bytes. The data path and the interrupt enable register are left untouched.
- R2: An interrupt enable write stores only data bits 3:0. A modem control write stores only data bits 4:0. The other bits read back as 0.
- R3: The interrupt ID reads 0x04 when line status bit 0 (data ready) and enable bit 0 are both 1. Otherwise it reads 0x02 when the hidden transmit-pending flag and enable bit 1 are both 1. Otherwise it reads 0x01.
- R4: `irq` is 1 exactly when the interrupt ID is not 0x01.
- R5: Reading offset 2 while it shows 0x02 clears transmit-pending. The ID is re-evaluated from the following cycle.
- R6: Reading offset 0 with divisor access off returns the received byte and clears line status bits 0 and 4 (data ready, break).
- R7: A break event loads 0x00 into the receive buffer and sets line status bits 4 and 0.
- R8: An interrupt enable write while line status bit 5 (holding register empty) is 1 sets transmit-pending.
- R9: With modem control bit 4 set, modem status reads as follows: control bits 3:2 at bits 7:6, control bit 1 at bit 4, control bit 0 at bit 5, and all other bits 0. With bit 4 clear, the stored modem status value is read.
- R10: After reset, line status reads 0x60, the interrupt ID reads 0x01, `irq` is 0, `rx_ready` is 1 and `tx_valid` is 0.
- R11: A data write with divisor access off raises `tx_valid` with the byte on `tx_data` for exactly the cycle after the write. Line status stays 0x60, and transmit-pending is set.
- R12: `rx_ready` is 0 while data ready is set. A byte offered then is dropped, and the held byte is kept.
- R13: Line control, modem status and scratch read back what was written. Writes to offsets 2 and 5 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (enables read side effects) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Break event |
| rx_ready | output | 1 | Receive buffer can take a byte |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_data | output | 8 | Transmitted byte |
| irq | output | 1 | Interrupt request |

## Verification
Read data is due in the strobe cycle itself. The bench drives each strobe at a falling edge and samples `rdata` one nanosecond later, before the next rising edge. Register updates, the `tx_valid` pulse, `rx_ready` and `irq` are all due one rising edge after the stimulus, so they are sampled at the next falling edge. A side effect of a read, such as clearing transmit-pending or data ready, shows only in a later transaction, and the checks read it back there. `tx_valid` is checked high at the first falling edge after the write and low at the one after that, which proves the pulse lasts one cycle.

// File: rtl/uart_rf_pkg.sv
// Shared constants for the serial controller register block: widths,
// register offsets, interrupt identification codes and flag bit positions.
package uart_rf_pkg;
    localparam int ADDR_W   = 3;
    localparam int DATA_W   = 8;
    localparam int DIV_W    = 2 * DATA_W;
    localparam int IER_W    = 4;
    localparam int MCR_W    = 5;

    localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_IER  = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_IID  = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_LCR  = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_MCR  = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_LSR  = 3'd5;
    localparam logic [ADDR_W-1:0] OFS_MSR  = 3'd6;
    localparam logic [ADDR_W-1:0] OFS_SCR  = 3'd7;

    localparam logic [DATA_W-1:0] IID_NONE = 8'h01;
    localparam logic [DATA_W-1:0] IID_THRE = 8'h02;
    localparam logic [DATA_W-1:0] IID_RXD  = 8'h04;

    localparam int LCR_DIVACC = 7;
    localparam int MCR_LOOP   = 4;
    localparam int IER_RXD    = 0;
    localparam int IER_THRE   = 1;
    localparam int LSR_THRE   = 5;
endpackage

// File: rtl/uart_rf_ctrl.sv
// Control register storage: line control, interrupt enable, modem control,
// modem status, scratch and the divisor latch. Decodes the write strobe and
// reports the data-register and enable-register writes for the line logic.
// Assumes one write per cycle; reset is synchronous and active low.
module uart_rf_ctrl
    import uart_rf_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   lcr_q,
    output logic [IER_W-1:0]    ier_q,
    output logic [MCR_W-1:0]    mcr_q,
    output logic [DATA_W-1:0]   msr_q,
    output logic [DATA_W-1:0]   scr_q,
    output logic [DIV_W-1:0]    div_q,
    output logic                data_wr,
    output logic                ier_wr
);
    logic divacc;

    // Divisor access selects what offsets 0 and 1 map to
    always_comb begin
        divacc  = lcr_q[LCR_DIVACC];
        data_wr = wr_en && (addr == OFS_DATA) && !divacc;
        ier_wr  = wr_en && (addr == OFS_IER)  && !divacc;
    end

    // Register storage updated by host writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lcr_q <= '0;
            ier_q <= '0;
            mcr_q <= '0;
            msr_q <= '0;
            scr_q <= '0;
            div_q <= '0;
        end else if (wr_en) begin
            case (addr)
                OFS_DATA: if (divacc) div_q[DATA_W-1:0] <= wdata;
                OFS_IER: begin
                    if (divacc) div_q[DIV_W-1:DATA_W] <= wdata;
                    else        ier_q <= wdata[IER_W-1:0];
                end
                OFS_LCR: lcr_q <= wdata;
                OFS_MCR: mcr_q <= wdata[MCR_W-1:0];
                OFS_MSR: msr_q <= wdata;
                OFS_SCR: scr_q <= wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/uart_rf_line.sv
// Line-side state: receive buffer, data-ready and break flags, the hidden
// transmit-pending flag and the one-cycle transmit strobe. The transmitter
// completes at once, so both empty flags read as set at all times.
module uart_rf_line
    import uart_rf_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                data_wr,
    input  logic                ier_wr,
    input  logic                rbr_rd,
    input  logic                thre_ack,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                rx_valid,
    input  logic [DATA_W-1:0]   rx_data,
    input  logic                rx_break,
    output logic                rx_ready,
    output logic [DATA_W-1:0]   rbr_q,
    output logic [DATA_W-1:0]   lsr,
    output logic                thr_pend_q,
    output logic                tx_valid,
    output logic [DATA_W-1:0]   tx_data
);
    logic dr_q, bi_q;

    // Assemble line status: empty flags fixed high, error flags zero
    always_comb begin
        lsr      = {1'b0, 1'b1, 1'b1, bi_q, 3'b000, dr_q};
        rx_ready = !dr_q;
    end

    // Receive buffer and its flags; a new arrival wins over a clearing read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbr_q <= '0;
            dr_q  <= 1'b0;
            bi_q  <= 1'b0;
        end else if (rx_break) begin
            rbr_q <= '0;
            dr_q  <= 1'b1;
            bi_q  <= 1'b1;
        end else if (rx_valid && !dr_q) begin
            rbr_q <= rx_data;
            dr_q  <= 1'b1;
        end else if (rbr_rd) begin
            dr_q  <= 1'b0;
            bi_q  <= 1'b0;
        end
    end

    // Transmit-pending flag: set by data or enable writes, cleared by ID read
    always_ff @(posedge clk) begin
        if (!rst_n)
            thr_pend_q <= 1'b0;
        else if (data_wr || (ier_wr && lsr[LSR_THRE]))
            thr_pend_q <= 1'b1;
        else if (thre_ack)
            thr_pend_q <= 1'b0;
    end

    // Transmit strobe lasting the cycle after a data write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            tx_valid <= data_wr;
            if (data_wr) tx_data <= wdata;
        end
    end
endmodule

// File: rtl/uart_rf_irq.sv
// Prioritised interrupt identification: received data over transmit empty.
// Purely combinational from registered state.
module uart_rf_irq
    import uart_rf_pkg::*;
(
    input  logic                dr,
    input  logic                thr_pend,
    input  logic                en_rxd,
    input  logic                en_thre,
    output logic [DATA_W-1:0]   iid,
    output logic                irq
);
    // Pick the highest-priority enabled source
    always_comb begin
        if (dr && en_rxd)            iid = IID_RXD;
        else if (thr_pend && en_thre) iid = IID_THRE;
        else                          iid = IID_NONE;
        irq = (iid != IID_NONE);
    end
endmodule

// File: rtl/uart_rf_modem.sv
// Modem status read path: in loopback the modem control outputs are routed
// to the status inputs; otherwise the stored status value is returned.
module uart_rf_modem
    import uart_rf_pkg::*;
(
    input  logic [MCR_W-1:0]    mcr,
    input  logic [DATA_W-1:0]   msr,
    output logic [DATA_W-1:0]   msr_rd
);
    // Loopback routing of control outputs into status inputs
    always_comb begin
        if (mcr[MCR_LOOP])
            msr_rd = {mcr[3], mcr[2], mcr[0], mcr[1], 4'b0000};
        else
            msr_rd = msr;
    end
endmodule

// File: rtl/uart_regfile.sv
// Top of the serial controller register block. Combines control storage,
// line-side state, interrupt encoding and the modem read path, and drives
// the combinational read mux. Assumes at most one host access per cycle.
module uart_regfile
    import uart_rf_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    input  logic                rx_valid,
    input  logic [DATA_W-1:0]   rx_data,
    input  logic                rx_break,
    output logic                rx_ready,
    output logic                tx_valid,
    output logic [DATA_W-1:0]   tx_data,
    output logic                irq
);
    logic [DATA_W-1:0] lcr_q, msr_q, scr_q, rbr_q, lsr, iid, msr_rd;
    logic [IER_W-1:0]  ier_q;
    logic [MCR_W-1:0]  mcr_q;
    logic [DIV_W-1:0]  div_q;
    logic              data_wr, ier_wr, thr_pend_q, rbr_rd, thre_ack, divacc;

    uart_rf_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .lcr_q(lcr_q), .ier_q(ier_q), .mcr_q(mcr_q), .msr_q(msr_q),
        .scr_q(scr_q), .div_q(div_q), .data_wr(data_wr), .ier_wr(ier_wr)
    );

    uart_rf_line u_line (
        .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .ier_wr(ier_wr),
        .rbr_rd(rbr_rd), .thre_ack(thre_ack), .wdata(wdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_break(rx_break),
        .rx_ready(rx_ready), .rbr_q(rbr_q), .lsr(lsr), .thr_pend_q(thr_pend_q),
        .tx_valid(tx_valid), .tx_data(tx_data)
    );

    uart_rf_irq u_irq (
        .dr(lsr[0]), .thr_pend(thr_pend_q),
        .en_rxd(ier_q[IER_RXD]), .en_thre(ier_q[IER_THRE]),
        .iid(iid), .irq(irq)
    );

    uart_rf_modem u_modem (.mcr(mcr_q), .msr(msr_q), .msr_rd(msr_rd));

    // Read side effects: buffer read and transmit-empty acknowledge
    always_comb begin
        divacc   = lcr_q[LCR_DIVACC];
        rbr_rd   = rd_en && (addr == OFS_DATA) && !divacc;
        thre_ack = rd_en && (addr == OFS_IID) && (iid == IID_THRE);
    end

    // Read data multiplexer
    always_comb begin
        case (addr)
            OFS_DATA: rdata = divacc ? div_q[DATA_W-1:0] : rbr_q;
            OFS_IER:  rdata = divacc ? div_q[DIV_W-1:DATA_W]
                                     : {{(DATA_W-IER_W){1'b0}}, ier_q};
            OFS_IID:  rdata = iid;
            OFS_LCR:  rdata = lcr_q;
            OFS_MCR:  rdata = {{(DATA_W-MCR_W){1'b0}}, mcr_q};
            OFS_LSR:  rdata = lsr;
            OFS_MSR:  rdata = msr_rd;
            default:  rdata = scr_q;
        endcase
    end
endmodule

// File: rtl/uart_rf_chk.sv
// Property checker for the register block, attached by bind.
module uart_rf_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] addr,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] rdata,
    input logic       rx_valid,
    input logic       rx_break,
    input logic       rx_ready,
    input logic       tx_valid,
    input logic       irq,
    input logic       divacc
);
    // R11
    tx_strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd0 && !divacc) |=> tx_valid);
    // R11
    tx_strobe_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == 3'd0 && !divacc) |=> !tx_valid);
    // R12
    rx_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready) |=> !rx_ready);
    // R6
    rx_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == 3'd0 && !divacc && !rx_valid && !rx_break) |=> rx_ready);
    // R5
    thre_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == 3'd2 && rdata == 8'h02 && !rx_valid && !rx_break) |=> !irq);
    // R4
    irq_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd2) |-> (irq == (rdata != 8'h01)));
    // R10
    reset_state_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (rx_ready && !irq && !tx_valid));
endmodule

bind uart_regfile uart_rf_chk u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .rdata(rdata), .rx_valid(rx_valid), .rx_break(rx_break),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .irq(irq), .divacc(lcr_q[7])
);

// File: tb/uart_regfile_tb_top.sv
`timescale 1ns/1ps
module uart_regfile_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0, rdata;
    logic       rx_valid = 1'b0, rx_break = 1'b0, rx_ready;
    logic [7:0] rx_data = '0, tx_data;
    logic       tx_valid, irq;
    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    uart_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_break(rx_break), .rx_ready(rx_ready), .tx_valid(tx_valid),
        .tx_data(tx_data), .irq(irq)
    );

    // Row: {is_read, offset, data-or-expected, requirement number}
    localparam int NV = 26;
    localparam logic [15:0] VECS [0:NV-1] = '{
        {1'b0, 3'd3, 8'h80, 4'd1},   // R1 divisor access on
        {1'b0, 3'd0, 8'h34, 4'd1},   // R1
        {1'b0, 3'd1, 8'h12, 4'd1},   // R1
        {1'b1, 3'd0, 8'h34, 4'd1},   // R1
        {1'b1, 3'd1, 8'h12, 4'd1},   // R1
        {1'b0, 3'd3, 8'h03, 4'd13},  // R13
        {1'b1, 3'd3, 8'h03, 4'd13},  // R13
        {1'b1, 3'd1, 8'h00, 4'd1},   // R1 enable untouched by divisor write
        {1'b0, 3'd1, 8'hFF, 4'd2},   // R2
        {1'b1, 3'd1, 8'h0F, 4'd2},   // R2
        {1'b1, 3'd2, 8'h02, 4'd8},   // R8 enable write re-armed pending
        {1'b1, 3'd2, 8'h01, 4'd5},   // R5 previous read cleared it
        {1'b0, 3'd4, 8'hFF, 4'd2},   // R2
        {1'b1, 3'd4, 8'h1F, 4'd2},   // R2
        {1'b1, 3'd6, 8'hF0, 4'd9},   // R9 loopback all set
        {1'b0, 3'd4, 8'h15, 4'd9},   // R9
        {1'b1, 3'd6, 8'h60, 4'd9},   // R9
        {1'b0, 3'd6, 8'h5A, 4'd13},  // R13
        {1'b0, 3'd4, 8'h00, 4'd9},   // R9 loopback off
        {1'b1, 3'd6, 8'h5A, 4'd9},   // R9
        {1'b0, 3'd7, 8'hA5, 4'd13},  // R13
        {1'b1, 3'd7, 8'hA5, 4'd13},  // R13
        {1'b0, 3'd5, 8'h00, 4'd13},  // R13 status write ignored
        {1'b1, 3'd5, 8'h60, 4'd13},  // R13
        {1'b0, 3'd2, 8'hFF, 4'd13},  // R13 ID write ignored
        {1'b1, 3'd2, 8'h01, 4'd13}   // R13
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic rx_push(input logic [7:0] d, input logic brk);
        @(negedge clk); rx_data = d; rx_valid = !brk; rx_break = brk;
        @(negedge clk); rx_valid = 1'b0; rx_break = 1'b0;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 irq", {7'd0, irq}, 8'h00);
        check("R10 rx_ready", {7'd0, rx_ready}, 8'h01);
        check("R10 tx_valid", {7'd0, tx_valid}, 8'h00);
        bus_rd(3'd5, v); check("R10 lsr", v, 8'h60);
        bus_rd(3'd2, v); check("R10 iid", v, 8'h01);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i][15]) begin
                bus_rd(VECS[i][14:12], v);
                check($sformatf("R%0d row %0d", VECS[i][3:0], i), v, VECS[i][11:4]);
            end else begin
                bus_wr(VECS[i][14:12], VECS[i][11:4]);
            end
        end

        // R11 transmit strobe; enables are 0x0F here
        bus_wr(3'd0, 8'h41);
        check("R11 tx_valid high", {7'd0, tx_valid}, 8'h01);
        check("R11 tx_data", tx_data, 8'h41);
        @(negedge clk);
        check("R11 tx_valid one cycle", {7'd0, tx_valid}, 8'h00);
        check("R4 irq on thre", {7'd0, irq}, 8'h01);
        bus_rd(3'd5, v); check("R11 lsr", v, 8'h60);
        bus_rd(3'd2, v); check("R3 iid thre", v, 8'h02);
        check("R5 irq cleared", {7'd0, irq}, 8'h00);

        // R12 receive, hold and drop
        rx_push(8'h77, 1'b0);
        check("R12 rx_ready low", {7'd0, rx_ready}, 8'h00);
        check("R4 irq on rxd", {7'd0, irq}, 8'h01);
        bus_rd(3'd5, v); check("R12 lsr dr", v, 8'h61);
        rx_push(8'h88, 1'b0);
        bus_rd(3'd0, v); check("R12 held byte", v, 8'h77);
        bus_rd(3'd5, v); check("R6 lsr cleared", v, 8'h60);
        check("R6 rx_ready back", {7'd0, rx_ready}, 8'h01);

        // R3 priority of received data over transmit empty
        bus_wr(3'd1, 8'h0F);
        rx_push(8'h11, 1'b0);
        bus_rd(3'd2, v); check("R3 rxd over thre", v, 8'h04);
        bus_rd(3'd0, v); check("R6 byte", v, 8'h11);
        bus_rd(3'd2, v); check("R3 thre after drain", v, 8'h02);

        // R7 break
        rx_push(8'hEE, 1'b1);
        bus_rd(3'd5, v); check("R7 lsr break", v, 8'h71);
        bus_rd(3'd2, v); check("R7 iid", v, 8'h04);
        bus_rd(3'd0, v); check("R7 rbr zero", v, 8'h00);
        bus_rd(3'd5, v); check("R6 break cleared", v, 8'h60);

        // R4 disabled sources raise nothing
        bus_wr(3'd1, 8'h00);
        rx_push(8'h22, 1'b0);
        check("R4 irq masked", {7'd0, irq}, 8'h00);
        bus_rd(3'd2, v); check("R3 iid masked", v, 8'h01);
        bus_rd(3'd0, v);

        // R10 reset in mid-run
        bus_wr(3'd3, 8'h9C);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        bus_rd(3'd3, v); check("R10 lcr after reset", v, 8'h00);
        bus_rd(3'd5, v); check("R10 lsr after reset", v, 8'h60);

        summary();
    end
endmodule